// File: doc/BRIEF.md
# BCH Syndrome Expansion Unit

This block turns the per-sector partial remainders of a binary BCH code over GF(2^13) into the full syndrome set S1..S2t that an error-locator solver consumes. The correction capability t is chosen per run from five values: 2, 4, 8, 12 or 24. Only the t odd-indexed syndromes are built from remainders. Each one is the sum of powers of alpha selected by the set bits of its remainder. Every even-indexed syndrome is then derived by squaring a lower-index one, so the unit reads only t remainders.

A run starts with a one-cycle strobe. The unit captures the capability code and the packed remainder words, clears every syndrome slot, and steps through one remainder bit per clock. It then squares its way up through the even slots in ascending order and raises a one-cycle completion flag. The syndrome array holds its values until the next accepted strobe. Field multiply and square are built from logic, with no lookup tables.

Top module: `bch_syn_expand`

## Requirements
- R1: After reset, `done` is low and every bit of `syn_out` is zero.
- R2: `cap_sel` codes 0, 1, 2, 3 and 4 select t = 2, 4, 8, 12 and 24. Codes 5 to 7, or any code whose t exceeds MAX_T, make a start strobe do nothing: no completion pulse follows, and `syn_out` keeps its value.
- R3: Remainder i (i = 0..t-1) sits in bits 16i+15..16i of `rem_words`. That is the low half of 32-bit word i/2 when i is even and the high half when i is odd. Only its bits 12..0 are used; bits 15..13 do not affect any result.
- R4: Odd syndrome S(2i+1) is the XOR, over every set bit j of remainder i, of alpha^((2i+1)*j mod 8191). The field is GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1, and alpha = 0x0002.
- R5: Even syndrome S(2q) equals S(q) squared in the same field, and is zero when S(q) is zero, for q = 1..t.
- R6: An accepted start clears every syndrome slot; slots above S(2t) read zero after the run. Syndrome S(n) is at `syn_out[13n-1 : 13n-13]`.
- R7: `done` is a one-cycle pulse, high in the cycle that follows clock edge E0+14t, where E0 is the edge that accepts the start.
- R8: A start strobe while a run is in progress is ignored. The run finishes with its original latency and produces exactly one completion pulse.
- R9: The capability code and remainder words are captured at the accepting edge. Later changes to these inputs during the run do not alter the result.
- R10: Between a completion pulse and the next accepted start, `syn_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that requests a run |
| cap_sel | input | 3 | Correction capability code |
| rem_words | input | 16*MAX_T | Packed partial remainders, two per 32-bit word |
| syn_out | output | 2*MAX_T*13 | Syndromes S1..S(2*MAX_T), 13 bits each |
| done | output | 1 | One-cycle completion pulse |

## Verification
Several properties are checked on every cycle: the completion flag lasts one cycle and arrives exactly 14t edges after an accepted start; the array is empty right after acceptance; the array stays frozen while idle; a rejected code leaves the unit idle. Whether each syndrome holds the right field value can only be shown by the bench scenarios. These compare every slot against an independent field model across single-bit, dense, all-zero, all-ones and mixed remainders at each capability. The scenarios also show that padding bits and inputs changed during a run have no effect, and that a strobe during a run is ignored.

// File: rtl/bch_syn_pkg.sv
package bch_syn_pkg;

   localparam int CAP_W   = 5;
   localparam int HALF_W  = 16;

   // capability code to t; zero marks an unsupported code
   function automatic logic [CAP_W-1:0] cap_decode(input logic [2:0] code);
      logic [CAP_W-1:0] t;
      case (code)
         3'd0:    t = 5'd2;
         3'd1:    t = 5'd4;
         3'd2:    t = 5'd8;
         3'd3:    t = 5'd12;
         3'd4:    t = 5'd24;
         default: t = 5'd0;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/bch_gf_mul.sv
module bch_gf_mul #(
   parameter int           M    = 13,
   parameter logic [M:0]   POLY = 14'h201B
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] p
);

   // interleaved shift-and-reduce product
   always_comb begin
      logic [M-1:0] run;
      logic [M-1:0] acc;
      run = a;
      acc = '0;
      for (int i = 0; i < M; i++) begin
         if (b[i]) acc = acc ^ run;
         run = {run[M-2:0], 1'b0} ^ (run[M-1] ? POLY[M-1:0] : '0);
      end
      p = acc;
   end

endmodule

// File: rtl/bch_gf_sqr.sv
module bch_gf_sqr #(
   parameter int           M         = 13,
   parameter logic [M:0]   POLY      = 14'h201B,
   parameter bit           SQ_BY_MUL = 1'b0
) (
   input  logic [M-1:0] a,
   output logic [M-1:0] q
);

   generate
      if (SQ_BY_MUL) begin : g_mul
         bch_gf_mul #(.M(M), .POLY(POLY)) u_mul (.a(a), .b(a), .p(q));
      end else begin : g_spread
         // squaring is linear: spread bits then fold the upper half down
         always_comb begin
            logic [2*M-2:0] d;
            d = '0;
            for (int i = 0; i < M; i++) d[2*i] = a[i];
            for (int k = 2*M-2; k >= M; k--) begin
               if (d[k]) d[k -: M+1] = d[k -: M+1] ^ POLY;
            end
            q = d[M-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/bch_syn_seq.sv
module bch_syn_seq
   import bch_syn_pkg::*;
#(
   parameter int M     = 13,
   parameter int MAX_T = 24,
   localparam int JW   = $clog2(M)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CAP_W-1:0] t_in,
   output logic             busy,
   output logic             accept,
   output logic             odd_step,
   output logic             odd_last,
   output logic [CAP_W-1:0] k_idx,
   output logic [JW-1:0]    j_idx,
   output logic             even_step,
   output logic [CAP_W-1:0] m_idx,
   output logic             done
);

   typedef enum logic [1:0] {S_IDLE, S_ODD, S_EVEN} seq_state_t;

   seq_state_t       state;
   logic [CAP_W-1:0] t_q;
   logic             t_ok;
   logic             j_end;

   assign t_ok      = (t_in != '0) && (int'(t_in) <= MAX_T);
   assign busy      = (state != S_IDLE);
   assign accept    = (state == S_IDLE) && start && t_ok;
   assign odd_step  = (state == S_ODD);
   assign j_end     = (int'(j_idx) == M-1);
   assign odd_last  = odd_step && j_end;
   assign even_step = (state == S_EVEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         t_q   <= '0;
         k_idx <= '0;
         j_idx <= '0;
         m_idx <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            S_IDLE: begin
               if (accept) begin
                  state <= S_ODD;
                  t_q   <= t_in;
                  k_idx <= '0;
                  j_idx <= '0;
                  m_idx <= '0;
               end
            end
            S_ODD: begin
               if (j_end) begin
                  j_idx <= '0;
                  if (k_idx == t_q - 1'b1) begin
                     state <= S_EVEN;
                     m_idx <= 5'd1;
                  end else begin
                     k_idx <= k_idx + 1'b1;
                  end
               end else begin
                  j_idx <= j_idx + 1'b1;
               end
            end
            S_EVEN: begin
               if (m_idx == t_q) begin
                  state <= S_IDLE;
                  done  <= 1'b1;
               end else begin
                  m_idx <= m_idx + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bch_syn_odd.sv
module bch_syn_odd #(
   parameter int           M    = 13,
   parameter logic [M:0]   POLY = 14'h201B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic         last,
   input  logic         bit_in,
   output logic [M-1:0] syn_val
);

   localparam logic [M-1:0] ONE    = M'(1);
   localparam logic [M-1:0] ALPHA  = M'(2);
   localparam logic [M-1:0] ALPHA2 = M'(4);

   logic [M-1:0] acc_q;   // partial sum of the current syndrome
   logic [M-1:0] pw_q;    // alpha^(i*j) for the current bit
   logic [M-1:0] base_q;  // alpha^i for the current odd index
   logic [M-1:0] pw_next;
   logic [M-1:0] base_next;

   bch_gf_mul #(.M(M), .POLY(POLY)) u_pw   (.a(pw_q),   .b(base_q), .p(pw_next));
   bch_gf_mul #(.M(M), .POLY(POLY)) u_base (.a(base_q), .b(ALPHA2), .p(base_next));

   assign syn_val = acc_q ^ (bit_in ? pw_q : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         pw_q   <= ONE;
         base_q <= ALPHA;
      end else if (load) begin
         acc_q  <= '0;
         pw_q   <= ONE;
         base_q <= ALPHA;
      end else if (step) begin
         if (last) begin
            acc_q  <= '0;
            pw_q   <= ONE;
            base_q <= base_next;
         end else begin
            acc_q  <= syn_val;
            pw_q   <= pw_next;
         end
      end
   end

endmodule

// File: rtl/bch_syn_expand.sv
module bch_syn_expand
   import bch_syn_pkg::*;
#(
   parameter int                 FIELD_M   = 13,
   parameter logic [FIELD_M:0]   POLY      = 14'h201B,
   parameter int                 MAX_T     = 24,
   parameter bit                 SQ_BY_MUL = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [2:0]                   cap_sel,
   input  logic [MAX_T*HALF_W-1:0]      rem_words,
   output logic [2*MAX_T*FIELD_M-1:0]   syn_out,
   output logic                         done
);

   localparam int NSYN = 2 * MAX_T;
   localparam int JW   = $clog2(FIELD_M);

   generate
      if (MAX_T < 2 || MAX_T > 24 || (MAX_T % 2) != 0) begin : g_bad_t
         $error("MAX_T must be even and within 2..24");
      end
      if (FIELD_M < 4 || FIELD_M > HALF_W) begin : g_bad_m
         $error("FIELD_M must lie within 4..16");
      end
      if (POLY[FIELD_M] != 1'b1 || POLY[0] != 1'b1) begin : g_bad_poly
         $error("POLY must have its top and constant terms set");
      end
   endgenerate

   logic [CAP_W-1:0]   t_dec;
   logic               busy;
   logic               accept;
   logic               odd_step;
   logic               odd_last;
   logic [CAP_W-1:0]   k_idx;
   logic [JW-1:0]      j_idx;
   logic               even_step;
   logic [CAP_W-1:0]   m_idx;
   logic               bit_in;
   logic [FIELD_M-1:0] odd_val;
   logic [FIELD_M-1:0] sq_src;
   logic [FIELD_M-1:0] sq_val;
   logic [FIELD_M-1:0] rem_q [MAX_T];
   logic [FIELD_M-1:0] syn_q [NSYN];

   assign t_dec = cap_decode(cap_sel);

   bch_syn_seq #(.M(FIELD_M), .MAX_T(MAX_T)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .t_in      (t_dec),
      .busy      (busy),
      .accept    (accept),
      .odd_step  (odd_step),
      .odd_last  (odd_last),
      .k_idx     (k_idx),
      .j_idx     (j_idx),
      .even_step (even_step),
      .m_idx     (m_idx),
      .done      (done)
   );

   // remainder capture: only the field bits of each 16-bit half are kept
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_T; i++) rem_q[i] <= '0;
      end else if (accept) begin
         for (int i = 0; i < MAX_T; i++) rem_q[i] <= rem_words[i*HALF_W +: FIELD_M];
      end
   end

   always_comb begin
      int kk;
      int jj;
      kk = (int'(k_idx) < MAX_T) ? int'(k_idx) : 0;
      jj = (int'(j_idx) < FIELD_M) ? int'(j_idx) : 0;
      bit_in = rem_q[kk][jj];
   end

   bch_syn_odd #(.M(FIELD_M), .POLY(POLY)) u_odd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (accept),
      .step    (odd_step),
      .last    (odd_last),
      .bit_in  (bit_in),
      .syn_val (odd_val)
   );

   always_comb begin
      int mm;
      mm = (m_idx != '0 && int'(m_idx) <= MAX_T) ? int'(m_idx) - 1 : 0;
      sq_src = syn_q[mm];
   end

   bch_gf_sqr #(.M(FIELD_M), .POLY(POLY), .SQ_BY_MUL(SQ_BY_MUL)) u_sqr (
      .a (sq_src),
      .q (sq_val)
   );

   // syndrome file: slot n-1 holds S(n)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < NSYN; n++) syn_q[n] <= '0;
      end else if (accept) begin
         for (int n = 0; n < NSYN; n++) syn_q[n] <= '0;
      end else if (odd_last) begin
         syn_q[2*int'(k_idx)] <= odd_val;
      end else if (even_step && m_idx != '0) begin
         syn_q[2*int'(m_idx)-1] <= sq_val;
      end
   end

   generate
      for (genvar n = 0; n < NSYN; n++) begin : g_out
         assign syn_out[n*FIELD_M +: FIELD_M] = syn_q[n];
      end
   endgenerate

endmodule

// File: rtl/bch_syn_expand_chk.sv
module bch_syn_expand_chk
   import bch_syn_pkg::*;
#(
   parameter int FIELD_M = 13,
   parameter int MAX_T   = 24
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic [2:0]                   cap_sel,
   input logic                         busy,
   input logic [2*MAX_T*FIELD_M-1:0]   syn_out,
   input logic                         done
);

   logic [CAP_W-1:0] t_now;
   logic             t_ok;
   logic             acc_c;
   logic [15:0]      edge_cnt;
   logic [CAP_W-1:0] t_run;

   assign t_now = cap_decode(cap_sel);
   assign t_ok  = (t_now != '0) && (int'(t_now) <= MAX_T);
   assign acc_c = !busy && start && t_ok;

   // edges elapsed since the accepting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         t_run    <= '0;
      end else if (acc_c) begin
         edge_cnt <= '0;
         t_run    <= t_now;
      end else if (edge_cnt != 16'hFFFF) begin
         edge_cnt <= edge_cnt + 1'b1;
      end
   end

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (int'(edge_cnt) == 14 * int'(t_run)));

   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_c |=> (syn_out == '0));

   p_bad_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && !t_ok) |=> !busy);

   p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(syn_out));

endmodule

bind bch_syn_expand bch_syn_expand_chk #(.FIELD_M(FIELD_M), .MAX_T(MAX_T)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .cap_sel (cap_sel),
   .busy    (busy),
   .syn_out (syn_out),
   .done    (done)
);

// File: tb/sim_bch_syn_expand.sv
module sim_bch_syn_expand;

   localparam int CLK_PERIOD = 10;
   localparam int MAX_T      = 24;
   localparam int M          = 13;
   localparam int SYN_W      = 2 * MAX_T * M;
   localparam int REM_W      = MAX_T * 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [2:0]       cap_sel = 3'd0;
   logic [REM_W-1:0] rem_words = '0;
   logic [SYN_W-1:0] syn_out;
   logic             done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int done_count = 0;
   int exp_done = 0;

   logic [SYN_W-1:0] exp_q[$];
   int               t_q[$];
   int               c_q[$];
   string            tag_q[$];

   bch_syn_expand u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cap_sel   (cap_sel),
      .rem_words (rem_words),
      .syn_out   (syn_out),
      .done      (done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   // carry-less product, reduced from the top bit down
   function automatic logic [12:0] gmul(input logic [12:0] a, input logic [12:0] b);
      logic [24:0] d;
      d = '0;
      for (int i = 0; i < 13; i++) if (b[i]) d = d ^ (25'(a) << i);
      for (int k = 24; k >= 13; k--) if (d[k]) d = d ^ (25'(14'h201B) << (k - 13));
      return d[12:0];
   endfunction

   function automatic logic [12:0] apow(input int e);
      logic [13:0] p;
      p = 14'd1;
      for (int i = 0; i < (e % 8191); i++) begin
         p = p << 1;
         if (p[13]) p = p ^ 14'h201B;
      end
      return p[12:0];
   endfunction

   function automatic logic [SYN_W-1:0] model(input int t, input logic [REM_W-1:0] r);
      logic [12:0]      s [0:2*MAX_T];
      logic [12:0]      rv;
      logic [SYN_W-1:0] o;
      for (int n = 0; n <= 2*MAX_T; n++) s[n] = '0;
      for (int i = 0; i < t; i++) begin
         rv = r[i*16 +: 13];
         for (int j = 0; j < 13; j++) if (rv[j]) s[2*i+1] = s[2*i+1] ^ apow((2*i+1)*j);
      end
      for (int q = 1; q <= t; q++) s[2*q] = gmul(s[q], s[q]);
      o = '0;
      for (int n = 1; n <= 2*MAX_T; n++) o[(n-1)*13 +: 13] = s[n];
      return o;
   endfunction

   // driver: pulse start and push the expected result
   task automatic run(input logic [2:0] code, input int t, input logic [REM_W-1:0] w, input string tag);
      logic [SYN_W-1:0] e;
      e = model(t, w);
      @(negedge clk);
      start = 1'b1; cap_sel = code; rem_words = w;
      @(negedge clk);
      start = 1'b0;
      exp_q.push_back(e); t_q.push_back(t); c_q.push_back(cyc); tag_q.push_back(tag);
      exp_done++;
   endtask

   task automatic wait_idle();
      while (exp_q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pop and compare on each completion pulse
   always @(negedge clk) begin
      if (rst_n && done) begin
         done_count++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R8 unexpected completion pulse", 64'd1, 64'd0);
         end else begin
            logic [SYN_W-1:0] e;
            int t, c0;
            string tg;
            e = exp_q.pop_front(); t = t_q.pop_front(); c0 = c_q.pop_front(); tg = tag_q.pop_front();
            chk((cyc - c0) == 14*t, {"R7 latency, run ", tg}, 64'(cyc - c0), 64'(14*t));
            for (int n = 1; n <= 2*MAX_T; n++) begin
               string kind;
               kind = (n > 2*t) ? "R6" : ((n % 2) == 1 ? "R4" : "R5");
               chk(syn_out[(n-1)*13 +: 13] == e[(n-1)*13 +: 13],
                   $sformatf("%s S%0d, run %s", kind, n, tg),
                   64'(syn_out[(n-1)*13 +: 13]), 64'(e[(n-1)*13 +: 13]));
            end
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual %0d expected below 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [REM_W-1:0] w;
      logic [REM_W-1:0] w2;
      logic [SYN_W-1:0] snap;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R1 done after reset", 64'(done), 64'd0);
      chk(syn_out == '0, "R1 syndromes after reset", 64'(syn_out[63:0]), 64'd0);

      // R4: single-bit remainders, t=2
      w = '0; w[0*16 +: 16] = 16'h0001; w[1*16 +: 16] = 16'h0002;
      run(3'd0, 2, w, "R4 single bit"); wait_idle();

      // R4: mixed patterns, t=4
      w = '0;
      w[0*16 +: 16] = 16'h1ABC; w[1*16 +: 16] = 16'h0F0F;
      w[2*16 +: 16] = 16'h1001; w[3*16 +: 16] = 16'h0155;
      run(3'd1, 4, w, "R4 mixed"); wait_idle();

      // R3: t=24, padding bits 15..13 frequently set
      for (int i = 0; i < MAX_T; i++) w[i*16 +: 16] = 16'((i * 32'h2F1 + 32'hE155) & 32'hFFFF);
      run(3'd4, 24, w, "R3 dense t24"); wait_idle();

      // R6: smaller t after a full run, upper slots must be zero
      for (int i = 0; i < MAX_T; i++) w[i*16 +: 16] = 16'((i * 32'h13 + 32'h7) & 32'h1FFF);
      run(3'd2, 8, w, "R6 t8 after t24"); wait_idle();

      // R5: all-zero remainders give all-zero syndromes
      run(3'd3, 12, '0, "R5 zero"); wait_idle();

      // R3: all ones including padding
      run(3'd3, 12, {REM_W{1'b1}}, "R3 ones"); wait_idle();

      // R8/R9: second strobe mid-run with new inputs is ignored
      for (int i = 0; i < MAX_T; i++) w[i*16 +: 16] = 16'((i * 32'h3A7 + 32'h91) & 32'hFFFF);
      for (int i = 0; i < MAX_T; i++) w2[i*16 +: 16] = 16'((i * 32'h55 + 32'h1234) & 32'hFFFF);
      run(3'd1, 4, w, "R8 R9 busy strobe");
      repeat (6) @(negedge clk);
      start = 1'b1; cap_sel = 3'd4; rem_words = w2;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (60) @(negedge clk);
      chk(done_count == exp_done, "R8 completion pulse count", 64'(done_count), 64'(exp_done));

      // R2/R10: unsupported code, outputs hold
      snap = syn_out;
      @(negedge clk);
      start = 1'b1; cap_sel = 3'd5; rem_words = w2;
      @(negedge clk);
      start = 1'b0; cap_sel = 3'd7;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (400) @(negedge clk);
      chk(done_count == exp_done, "R2 no pulse for bad code", 64'(done_count), 64'(exp_done));
      chk(syn_out == snap, "R10 syndromes held while idle", 64'(syn_out[63:0]), 64'(snap[63:0]));

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule